// File: doc/BRIEF.md
# Variable-Width Sample Packer

The packer sits between the sampling front end of a logic analyzer and a capture memory whose word is always 32 bits wide. A width code picks the sample size: 32, 16, 8, 4 or 2 bits. Consecutive valid samples are gathered in a holding register. Each time the word is full, the block writes it to the memory port with a one-cycle write enable and an address that steps through the memory. With narrow samples, one memory word therefore holds several samples, and the same memory captures two to sixteen times as many of them.

Samples fill the word from the least-significant lane upwards. A flush request writes out a word that is only partly filled, with the lanes that were never written set to zero. Changing the width code drops any partly filled word, and the next sample starts a fresh word at lane 0. The write address wraps at the memory depth, which is 2^ADDR_W words.

Top module: `sample_packer`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the write enable, sets the write address to 0 and discards any partly filled word; a flush issued right after reset with no sample writes nothing.
- R2: Width code 0 selects 32-bit samples, and codes 5, 6 and 7 behave the same way. Every valid sample is written unchanged as one memory word.
- R3: Width code 1 selects 16-bit samples. One word is written for every second valid sample: the first sample goes to bits [15:0] and the second to bits [31:16].
- R4: Width code 2 selects 8-bit samples. One word is written for every fourth valid sample, and the n-th sample of the word (n = 0..3) goes to bits [8n+7:8n].
- R5: Width code 3 packs eight 4-bit samples and width code 4 packs sixteen 2-bit samples per word. Sample n goes to bits [b*n+b-1:b*n], where b is the sample width, so the sample that completes a word always sits in the top lane.
- R6: For a sample width b, only `smp_data[b-1:0]` is used. The upper bits of the input have no effect on the written word.
- R7: `mem_we` is high for exactly the one cycle after the clock edge that takes in the sample which completes a word, or after the flush edge. It is never high unless `smp_valid` or `flush` was high at the previous edge.
- R8: Each write uses the address of the previous write plus one. The first write after reset uses address 0, and the address wraps from 2^ADDR_W-1 to 0.
- R9: A flush while lanes are held writes the partly filled word and zeroes the unused upper lanes. A sample that is valid in the same cycle as the flush is included in that word, in the next lane.
- R10: A flush when no lane is held and no sample is valid writes nothing.
- R11: When the width code differs from its value at the previous edge, the held lanes are discarded without a write. A sample valid in that cycle becomes lane 0 of a new word at the new width.
- R12: Cycles with `smp_valid` low use up no lane, so idle gaps between samples do not change the packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 32 | Sample value, right-aligned |
| width_sel | input | 3 | Sample width code (0:32, 1:16, 2:8, 3:4, 4:2 bits; 5 to 7 act as 32) |
| flush | input | 1 | Write out the partly filled word |
| mem_we | output | 1 | Memory write enable, one pulse per word |
| mem_addr | output | ADDR_W | Write address of the current word |
| mem_wdata | output | 32 | Packed memory word |

## Verification
Several properties are checked on every cycle. Reset leaves the port idle at address 0, and consecutive writes advance the address by exactly one, wraparound included. In 32-bit mode each sample reaches the memory unchanged one cycle later. Every write that is not caused by a flush carries the sample that completed it in the top lane, and no write appears without a sample or a flush before it. Only the bench's scenarios can show lane ordering across a whole word, zero padding on flush, discarding on a width change, the effect of idle gaps and masking of the unused upper input bits. The bench does this by comparing against a queue-based model on every clock.

// File: rtl/pack_pkg.sv
package pack_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned MIN_W  = 2;
    localparam int unsigned NSLICE = WORD_W / MIN_W;
    localparam int unsigned CNT_W  = $clog2(NSLICE);

    typedef enum logic [2:0] {
        WSEL_32 = 3'd0,
        WSEL_16 = 3'd1,
        WSEL_8  = 3'd2,
        WSEL_4  = 3'd3,
        WSEL_2  = 3'd4
    } wsel_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    function automatic int unsigned lane_bits(input logic [2:0] code);
        case (wsel_e'(code))
            WSEL_16: lane_bits = 16;
            WSEL_8:  lane_bits = 8;
            WSEL_4:  lane_bits = 4;
            WSEL_2:  lane_bits = 2;
            default: lane_bits = 32;
        endcase
    endfunction

    function automatic int unsigned lanes_per_word(input logic [2:0] code);
        lanes_per_word = WORD_W / lane_bits(code);
    endfunction

    function automatic int unsigned slice_shift(input logic [2:0] code);
        case (wsel_e'(code))
            WSEL_16: slice_shift = 3;
            WSEL_8:  slice_shift = 2;
            WSEL_4:  slice_shift = 1;
            WSEL_2:  slice_shift = 0;
            default: slice_shift = 4;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_mask(input logic [2:0] code);
        if (lane_bits(code) >= WORD_W)
            lane_mask = '1;
        else
            lane_mask = (WORD_W'(1) << lane_bits(code)) - WORD_W'(1);
    endfunction

endpackage

// File: rtl/packer_lane_ctrl.sv
module packer_lane_ctrl
    import pack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             flush,
    input  logic [2:0]       width_sel,
    output logic [CNT_W-1:0] lane_idx,
    output logic             mode_chg,
    output logic             do_write
);
    logic [2:0]       width_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_lane;
    logic             filled;
    logic             held;

    always_comb begin
        mode_chg  = (width_sel != width_q);
        lane_idx  = mode_chg ? '0 : cnt_q;
        last_lane = CNT_W'(lanes_per_word(width_sel) - 1);
        filled    = smp_valid && (lane_idx == last_lane);
        held      = (lane_idx != '0);
        do_write  = filled || (flush && (held || smp_valid));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= WSEL_32;
            cnt_q   <= '0;
        end else begin
            width_q <= width_sel;
            if (do_write)
                cnt_q <= '0;
            else
                cnt_q <= lane_idx + CNT_W'(smp_valid);
        end
    end

endmodule

// File: rtl/packer_merge.sv
module packer_merge
    import pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [WORD_W-1:0] smp_data,
    input  logic [2:0]        width_sel,
    input  logic [CNT_W-1:0]  lane_idx,
    input  logic              mode_chg,
    input  logic              do_write,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] base;

    assign base = mode_chg ? '0 : hold_q;

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        int unsigned sh;
        int unsigned lane_of;
        int unsigned k;
        logic        hit;
        always_comb begin
            sh      = slice_shift(width_sel);
            lane_of = s >> sh;
            k       = s & ((32'd1 << sh) - 1);
            hit     = smp_valid && (lane_of == 32'(lane_idx));
            merged[s*MIN_W +: MIN_W] = hit ? smp_data[k*MIN_W +: MIN_W]
                                           : base[s*MIN_W +: MIN_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || do_write)
            hold_q <= '0;
        else
            hold_q <= merged;
    end

endmodule

// File: rtl/packer_wr_port.sv
module packer_wr_port
    import pack_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= req.we;
            if (req.we) begin
                mem_addr  <= ptr_q;
                mem_wdata <= req.data;
                ptr_q     <= ptr_q + ADDR_W'(1);
            end
        end
    end

endmodule

// File: rtl/sample_packer.sv
module sample_packer
    import pack_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [31:0]       smp_data,
    input  logic [2:0]        width_sel,
    input  logic              flush,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    logic [CNT_W-1:0]  lane_idx;
    logic              mode_chg;
    logic              do_write;
    logic [WORD_W-1:0] merged;
    wr_req_t           req;

    packer_lane_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .flush     (flush),
        .width_sel (width_sel),
        .lane_idx  (lane_idx),
        .mode_chg  (mode_chg),
        .do_write  (do_write)
    );

    packer_merge u_merge (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .width_sel (width_sel),
        .lane_idx  (lane_idx),
        .mode_chg  (mode_chg),
        .do_write  (do_write),
        .merged    (merged)
    );

    assign req.we   = do_write;
    assign req.data = merged;

    packer_wr_port #(.ADDR_W(ADDR_W)) u_port (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

endmodule

// File: rtl/packer_chk.sv
module packer_chk
    import pack_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [31:0]       smp_data,
    input logic [2:0]        width_sel,
    input logic              flush,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata
);
    logic [ADDR_W-1:0] last_addr;
    logic              seen_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_wr   <= 1'b0;
            last_addr <= '0;
        end else if (mem_we) begin
            seen_wr   <= 1'b1;
            last_addr <= mem_addr;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!mem_we && mem_addr == '0));

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_we && seen_wr) |-> (mem_addr == ADDR_W'(last_addr + ADDR_W'(1))));

    assert_direct_word_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(smp_valid) && lanes_per_word($past(width_sel)) == 1)
        |-> (mem_we && mem_wdata == $past(smp_data)));

    assert_top_lane_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(rst) && !$past(flush))
        |-> ((mem_wdata >> (WORD_W - lane_bits($past(width_sel))))
             == ($past(smp_data) & lane_mask($past(width_sel)))));

    assert_write_cause_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (!$past(rst) && ($past(smp_valid) || $past(flush))));

endmodule

bind sample_packer packer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .width_sel (width_sel),
    .flush     (flush),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/sample_packer_tb_top.sv
module sample_packer_tb_top;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_valid = 1'b0;
    logic [31:0]   smp_data = '0;
    logic [2:0]    width_sel = 3'd0;
    logic          flush = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;

    always #10 clk = ~clk;

    sample_packer #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .width_sel (width_sel),
        .flush     (flush),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [31:0] q[$];
    int          mw = 0;
    int          maddr = 0;

    function automatic int bits_of(input int c);
        case (c)
            1: return 16;
            2: return 8;
            3: return 4;
            4: return 2;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] gen(input int i);
        return (32'h9E3779B9 * i) ^ 32'h5A5A0F0F;
    endfunction

    task automatic check(input string req, input logic e_we,
                         input logic [31:0] e_d, input int e_a);
        n_vec++;
        if (mem_we !== e_we ||
            (e_we && (mem_wdata !== e_d || mem_addr !== AW'(e_a)))) begin
            n_bad++;
            $display("FAIL %s: got we=%0b data=%h addr=%0d, expected we=%0b data=%h addr=%0d",
                     req, mem_we, mem_wdata, mem_addr, e_we, e_d, e_a);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] d, input int w,
                        input logic f, input string req);
        int          b;
        int          lanes;
        logic        e_we;
        logic [31:0] e_d;
        int          e_a;
        smp_valid = v;
        smp_data  = d;
        width_sel = w[2:0];
        flush     = f;
        b     = bits_of(w);
        lanes = 32 / b;
        e_we  = 1'b0;
        e_d   = '0;
        e_a   = 0;
        if (w != mw) begin
            q.delete();
            mw = w;
        end
        if (v) q.push_back(b == 32 ? d : (d & ((32'd1 << b) - 32'd1)));
        if (q.size() == lanes || (f && q.size() > 0)) begin
            foreach (q[i]) e_d |= q[i] << (i * b);
            e_we  = 1'b1;
            e_a   = maddr;
            maddr = (maddr + 1) % DEPTH;
            q.delete();
        end
        @(posedge clk);
        @(negedge clk);
        check(req, e_we, e_d, e_a);
    endtask

    task automatic do_reset();
        smp_valid = 1'b0;
        flush     = 1'b0;
        width_sel = 3'd0;
        rst       = 1'b1;
        q.delete();
        mw    = 0;
        maddr = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_vec++;
        if (mem_we !== 1'b0 || mem_addr !== '0) begin
            n_bad++;
            $display("FAIL R1: got we=%0b addr=%0d, expected we=0 addr=0", mem_we, mem_addr);
        end
    endtask

    task automatic run(input int w, input int n, input int seed, input string req);
        for (int i = 0; i < n; i++) step(1'b1, gen(seed + i), w, 1'b0, req);
    endtask

    function automatic void summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run still active, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();                                  // R1
        run(0, 3, 1, "R2");
        step(1'b0, 32'hFFFF_FFFF, 0, 1'b0, "R12");
        run(0, 2, 10, "R2");
        run(1, 2, 20, "R3");
        step(1'b1, 32'hABCD_1234, 1, 1'b0, "R3");
        step(1'b0, 32'h0, 1, 1'b0, "R12");
        step(1'b0, 32'h0, 1, 1'b0, "R12");
        run(1, 3, 30, "R3");
        run(2, 8, 40, "R4");
        run(2, 4, 50, "R6");
        run(3, 16, 60, "R5");
        run(4, 16, 80, "R5");
        step(1'b0, 32'h0, 4, 1'b0, "R12");
        run(4, 16, 100, "R5");
        run(6, 3, 120, "R2");
        run(2, 2, 130, "R9");
        step(1'b0, 32'h0, 2, 1'b1, "R9");
        run(3, 3, 140, "R9");
        step(1'b1, gen(150), 3, 1'b1, "R9");
        step(1'b0, 32'h0, 3, 1'b1, "R10");
        step(1'b0, 32'h0, 3, 1'b1, "R10");
        step(1'b1, gen(160), 1, 1'b0, "R11");
        step(1'b1, gen(161), 2, 1'b0, "R11");
        run(2, 3, 162, "R11");
        run(3, 3, 170, "R11");
        step(1'b0, 32'h0, 4, 1'b0, "R11");
        step(1'b0, 32'h0, 4, 1'b1, "R11");
        run(2, 2, 180, "R1");
        do_reset();
        step(1'b0, 32'h0, 0, 1'b1, "R1");
        run(0, 2 * DEPTH + 3, 200, "R8");
        run(1, 6, 300, "R7");
        finished = 1;
        summary();
        $finish;
    end

endmodule